// File: doc/BRIEF.md
# DMA Block Chaining Controller

This block manages the end of every data block for one DMA channel. It holds the live transfer state: two address counters and a remaining-item count. It also holds a second, shadow set of the same three values that software fills in for the next block. A separate transfer sequencer moves the data. It pulses `item_done_i` once per item moved, and it reads the live addresses from the block's outputs.

Software programs the block through a write-only port. To arm a block, it writes both shadow addresses first and the shadow count last. Writing the count marks the shadow set as valid. The channel runs in one of two modes:
- **Single mode:** the channel stops when the count reaches zero.
- **Double-buffer mode:** when the count reaches zero, the channel either moves to the armed shadow set in the same cycle, or stops and flags an overrun if no shadow set was armed.

Four flags (valid, terminal count, overrun, active) and one interrupt line report the channel state.

Top module: `dma_chain_ctrl`

Register map (word index on `wr_addr_i`):
- 0: control word.
- 1: shadow address A.
- 2: shadow address B.
- 3: shadow count.
- 4: status clear. Each 1 bit clears one flag: bit 0 = valid, bit 1 = terminal count, bit 2 = overrun.

Control word bits:
- bit 0: enable.
- bit 1: double-buffer mode.
- bit 2: terminal-count interrupt enable.
- bit 3: overrun interrupt enable.
- bit 4: step address A by +1 per item.
- bit 5: step address B by +1 per item.

## Requirements
- R1: After reset, every counter, shadow value, control bit and flag is 0, and `irq_o` is 0.
- R2: A write to index 3 sets the valid flag. Writing status with bit 0 set clears the valid flag, but a count write in the same cycle wins.
- R3: When a control write sets bit 0 while the stored enable is 0, the active counters load from the shadow set and the valid flag clears. If the shadow count is nonzero, the active flag sets. If the shadow count is zero, the terminal-count flag sets instead and the active flag stays 0.
- R4: Each `item_done_i` pulse while the channel is active decrements the count by 1. It also adds 1 to address A when bit 4 is set, and adds 1 to address B when bit 5 is set. A pulse while the channel is inactive changes nothing.
- R5: In single mode, the item that brings the count to 0 sets the terminal-count flag and clears the active flag.
- R6: In double-buffer mode with the valid flag set, the item that brings the count to 0 sets the terminal-count flag in the same cycle. In that cycle the shadow set is copied into the active counters and the valid flag clears. The active flag stays set when the copied count is nonzero.
- R7: In double-buffer mode with the valid flag clear, the item that brings the count to 0 sets both the terminal-count and overrun flags and clears the active flag.
- R8: `irq_o` is 1 exactly when (terminal count AND bit 2) OR (overrun AND bit 3). It follows the registered flags and control bits.
- R9: Writing status with bit 1 set clears the terminal-count flag, and writing it with bit 2 set clears the overrun flag. A set event in the same cycle wins over the clear.
- R10: A control write with bit 0 clear clears the active flag. A control write with bit 0 set while already enabled updates the mode bits but does not reload the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register index |
| wr_data_i | input | 16 | Write data |
| item_done_i | input | 1 | One item moved by the sequencer |
| addr_a_o | output | 16 | Live address A |
| addr_b_o | output | 16 | Live address B |
| count_o | output | 16 | Live remaining item count |
| valid_o | output | 1 | Shadow set armed |
| tc_o | output | 1 | Terminal-count flag |
| ovr_o | output | 1 | Overrun flag |
| active_o | output | 1 | Channel active |
| irq_o | output | 1 | Interrupt request |

## Verification
Every result is held in a register. A write or an item pulse seen at one rising edge is therefore visible on the outputs just after that same edge, and this holds for a block end and its reload as well. `irq_o` is decoded from the registered flags, so it changes in that same cycle too. The bench changes its inputs on the falling edge, waits for the next rising edge plus a short settle time, and only then compares every output with a cycle-level model.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_SHA   = 3'd1,
    REG_SHB   = 3'd2,
    REG_SHCNT = 3'd3,
    REG_STAT  = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic step_b;
    logic step_a;
    logic ovr_ie;
    logic tc_ie;
    logic dbl;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dma_chain_shadow.sv
module dma_chain_shadow
  import dma_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int WD = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [WD-1:0] wr_data_i,
  input  logic          consume_i,
  output ctrl_t         ctrl_o,
  output logic [AW-1:0] sha_o,
  output logic [AW-1:0] shb_o,
  output logic [CW-1:0] shc_o,
  output logic          vld_o
);
  logic wr_cnt, clr_vld;
  assign wr_cnt  = wr_en_i && (wr_addr_i == REG_SHCNT);
  assign clr_vld = consume_i || (wr_en_i && (wr_addr_i == REG_STAT) && wr_data_i[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      sha_o  <= '0;
      shb_o  <= '0;
      shc_o  <= '0;
      vld_o  <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == REG_CTRL) ctrl_o <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_en_i && wr_addr_i == REG_SHA)  sha_o  <= wr_data_i[AW-1:0];
      if (wr_en_i && wr_addr_i == REG_SHB)  shb_o  <= wr_data_i[AW-1:0];
      if (wr_cnt)                           shc_o  <= wr_data_i[CW-1:0];
      if (wr_cnt)       vld_o <= 1'b1;
      else if (clr_vld) vld_o <= 1'b0;
    end
  end

  assert_valid_set_R2: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> vld_o);
  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (consume_i && !wr_cnt) |=> !vld_o);
endmodule

// File: rtl/dma_chain_active.sv
module dma_chain_active #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          inc_a_i,
  input  logic          inc_b_i,
  input  logic [AW-1:0] sha_i,
  input  logic [AW-1:0] shb_i,
  input  logic [CW-1:0] shc_i,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_a_o <= '0;
      addr_b_o <= '0;
      cnt_o    <= '0;
    end else if (load_i) begin
      addr_a_o <= sha_i;
      addr_b_o <= shb_i;
      cnt_o    <= shc_i;
    end else if (step_i) begin
      addr_a_o <= addr_a_o + AW'(inc_a_i);
      addr_b_o <= addr_b_o + AW'(inc_b_i);
      cnt_o    <= cnt_o - CW'(1);
    end
  end

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(cnt_o) && $stable(addr_a_o) && $stable(addr_b_o));
  assert_step_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> cnt_o == $past(cnt_o) - CW'(1));
endmodule

// File: rtl/dma_chain_status.sv
module dma_chain_status
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctrl_t      ctrl_i,
  input  logic       clr_wr_i,
  input  logic [2:0] clr_bits_i,
  input  logic       set_tc_i,
  input  logic       set_ovr_i,
  input  logic       go_i,
  input  logic       halt_i,
  output logic       tc_o,
  output logic       ovr_o,
  output logic       act_o,
  output logic       irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_o  <= 1'b0;
      ovr_o <= 1'b0;
      act_o <= 1'b0;
    end else begin
      if (set_tc_i)                          tc_o <= 1'b1;
      else if (clr_wr_i && clr_bits_i[1])    tc_o <= 1'b0;
      if (set_ovr_i)                         ovr_o <= 1'b1;
      else if (clr_wr_i && clr_bits_i[2])    ovr_o <= 1'b0;
      if (halt_i)    act_o <= 1'b0;
      else if (go_i) act_o <= 1'b1;
    end
  end

  assign irq_o = (tc_o && ctrl_i.tc_ie) || (ovr_o && ctrl_i.ovr_ie);

  assert_ovr_dbl_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o) |-> ($past(ctrl_i.dbl) && !act_o));
  assert_tc_set_R9: assert property (@(posedge clk) disable iff (rst)
    set_tc_i |=> tc_o);
  assert_irq_src_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (tc_o || ovr_o));
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int WD = (AW > CW) ? AW : CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [WD-1:0] wr_data_i,
  input  logic          item_done_i,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output logic [CW-1:0] count_o,
  output logic          valid_o,
  output logic          tc_o,
  output logic          ovr_o,
  output logic          active_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic [AW-1:0] sha, shb;
  logic [CW-1:0] shc;
  logic ctrl_wr, start, stop, step, eob_run, reload, finish, zero_start;
  logic load, consume, go, halt;

  assign ctrl_wr    = wr_en_i && (wr_addr_i == REG_CTRL);
  assign start      = ctrl_wr && wr_data_i[0] && !ctrl.en;
  assign stop       = ctrl_wr && !wr_data_i[0];
  assign step       = item_done_i && active_o && (count_o != '0);
  assign eob_run    = step && (count_o == CW'(1));
  assign reload     = eob_run && ctrl.dbl && valid_o;
  assign finish     = eob_run && !reload;
  assign zero_start = start && (shc == '0);
  assign load       = start || reload;
  assign consume    = load;
  assign go         = load && (shc != '0);
  assign halt       = stop || finish || (load && (shc == '0));

  dma_chain_shadow #(.AW(AW), .CW(CW), .WD(WD)) u_shadow (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .consume_i(consume), .ctrl_o(ctrl),
    .sha_o(sha), .shb_o(shb), .shc_o(shc), .vld_o(valid_o)
  );

  dma_chain_active #(.AW(AW), .CW(CW)) u_active (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step),
    .inc_a_i(ctrl.step_a), .inc_b_i(ctrl.step_b),
    .sha_i(sha), .shb_i(shb), .shc_i(shc),
    .addr_a_o(addr_a_o), .addr_b_o(addr_b_o), .cnt_o(count_o)
  );

  dma_chain_status u_status (
    .clk(clk), .rst(rst), .ctrl_i(ctrl),
    .clr_wr_i(wr_en_i && (wr_addr_i == REG_STAT)), .clr_bits_i(wr_data_i[2:0]),
    .set_tc_i(eob_run || zero_start), .set_ovr_i(finish && ctrl.dbl),
    .go_i(go), .halt_i(halt),
    .tc_o(tc_o), .ovr_o(ovr_o), .act_o(active_o), .irq_o(irq_o)
  );

  assert_active_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (count_o != '0));
  assert_reload_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (reload && (shc != '0) && !stop) |=> (active_o && tc_o && count_o == $past(shc)));
  assert_single_end_R5: assert property (@(posedge clk) disable iff (rst)
    (eob_run && !ctrl.dbl) |=> (!active_o && tc_o));
  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (rst)
    stop |=> !active_o);
endmodule

// File: tb/sim_dma_chain_ctrl.sv
module sim_dma_chain_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic we = 1'b0, dn = 1'b0;
  logic [2:0] ad = '0;
  logic [15:0] wd = '0;
  logic [15:0] a_o, b_o, c_o;
  logic v_o, tc_o, ov_o, act_o, irq_o;
  int errs = 0, checks = 0;
  bit done_flag = 0;

  // model state
  logic [5:0]  m_ctrl;
  logic [15:0] m_sa, m_sb, m_sc, m_a, m_b, m_c;
  logic m_v, m_tc, m_ov, m_act;

  always #5 clk = ~clk;

  dma_chain_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en_i(we), .wr_addr_i(ad), .wr_data_i(wd),
    .item_done_i(dn), .addr_a_o(a_o), .addr_b_o(b_o), .count_o(c_o),
    .valid_o(v_o), .tc_o(tc_o), .ovr_o(ov_o), .active_o(act_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_irq();
    return (m_tc && m_ctrl[2]) || (m_ov && m_ctrl[3]);
  endfunction

  task automatic mreset();
    m_ctrl = '0; m_sa = '0; m_sb = '0; m_sc = '0; m_a = '0; m_b = '0; m_c = '0;
    m_v = 0; m_tc = 0; m_ov = 0; m_act = 0;
  endtask

  task automatic compare_all();
    chk("R4 addr_a", a_o, m_a);
    chk("R4 addr_b", b_o, m_b);
    chk("R4 count", c_o, m_c);
    chk("R2 valid", 16'(v_o), 16'(m_v));
    chk("R5 tc", 16'(tc_o), 16'(m_tc));
    chk("R7 ovr", 16'(ov_o), 16'(m_ov));
    chk("R6 active", 16'(act_o), 16'(m_act));
    chk("R8 irq", 16'(irq_o), 16'(exp_irq()));
  endtask

  // one clock: drive on falling edge, advance model, sample after rising edge
  task automatic cyc(input logic w, input logic [2:0] a, input logic [15:0] d, input logic n);
    logic st, sp, stp, eob, rl, fin, wrc;
    logic [5:0] nctrl;
    logic [15:0] nsa, nsb, nsc, na, nb, nc;
    logic nv, ntc, nov, nact;
    @(negedge clk);
    we = w; ad = a; wd = d; dn = n;
    st  = w && a == 3'd0 && d[0] && !m_ctrl[0];
    sp  = w && a == 3'd0 && !d[0];
    stp = n && m_act && m_c != 0;
    eob = stp && m_c == 16'd1;
    rl  = eob && m_ctrl[1] && m_v;
    fin = eob && !rl;
    wrc = w && a == 3'd3;
    nctrl = (w && a == 3'd0) ? d[5:0] : m_ctrl;
    nsa = (w && a == 3'd1) ? d : m_sa;
    nsb = (w && a == 3'd2) ? d : m_sb;
    nsc = wrc ? d : m_sc;
    na = m_a; nb = m_b; nc = m_c;
    if (st || rl) begin na = m_sa; nb = m_sb; nc = m_sc; end
    else if (stp) begin na = m_a + 16'(m_ctrl[4]); nb = m_b + 16'(m_ctrl[5]); nc = m_c - 1; end
    nv = m_v;
    if (st || rl || (w && a == 3'd4 && d[0])) nv = 0;
    if (wrc) nv = 1;
    ntc = m_tc;
    if (w && a == 3'd4 && d[1]) ntc = 0;
    if (eob || (st && m_sc == 0)) ntc = 1;
    nov = m_ov;
    if (w && a == 3'd4 && d[2]) nov = 0;
    if (fin && m_ctrl[1]) nov = 1;
    nact = m_act;
    if ((st || rl) && m_sc != 0) nact = 1;
    if (sp || fin || ((st || rl) && m_sc == 0)) nact = 0;
    @(posedge clk); #1;
    m_ctrl = nctrl; m_sa = nsa; m_sb = nsb; m_sc = nsc; m_a = na; m_b = nb; m_c = nc;
    m_v = nv; m_tc = ntc; m_ov = nov; m_act = nact;
    compare_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic pulse();
    cyc(1'b0, 3'd0, 16'd0, 1'b1);
  endtask

  task automatic arm(input logic [15:0] sa, input logic [15:0] sb, input logic [15:0] sc);
    wr(3'd1, sa); wr(3'd2, sb); wr(3'd3, sc);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    mreset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 count", c_o, 16'd0);
    chk("R1 flags", 16'({v_o, tc_o, ov_o, act_o, irq_o}), 16'd0);

    // R2 arming
    arm(16'h0100, 16'h0200, 16'd3);
    chk("R2 valid after count write", 16'(v_o), 16'd1);
    // R3 start in single mode: en|tc_ie|step_a|step_b
    wr(3'd0, 16'h0035);
    chk("R3 loaded count", c_o, 16'd3);
    chk("R3 valid consumed", 16'(v_o), 16'd0);
    chk("R3 active", 16'(act_o), 16'd1);
    pulse(); pulse(); pulse();
    chk("R5 addr_a after block", a_o, 16'h0103);
    chk("R5 tc and inactive", 16'({tc_o, act_o}), 16'b10);
    chk("R8 irq on tc", 16'(irq_o), 16'd1);
    wr(3'd4, 16'h0002);
    chk("R9 tc cleared", 16'({tc_o, irq_o}), 16'd0);
    pulse();
    chk("R4 pulse ignored when idle", c_o, 16'd0);

    // double-buffer: disable, arm, start, arm next, reload, then overrun
    wr(3'd0, 16'h0000);
    arm(16'h1000, 16'h2000, 16'd2);
    wr(3'd0, 16'h001F);
    arm(16'h3000, 16'h4000, 16'd2);
    chk("R2 re-armed", 16'(v_o), 16'd1);
    pulse(); pulse();
    chk("R6 reloaded addr", a_o, 16'h3000);
    chk("R6 still active", 16'({act_o, tc_o, v_o}), 16'b110);
    wr(3'd0, 16'h001F);
    chk("R10 no reload while enabled", a_o, 16'h3000);
    pulse(); pulse();
    chk("R7 overrun", 16'({ov_o, tc_o, act_o}), 16'b110);
    // R9 set wins over clear in same cycle is covered by random; clear both
    wr(3'd4, 16'h0006);
    chk("R9 both cleared", 16'({ov_o, tc_o}), 16'd0);

    // R3 zero-count start
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h0001);
    chk("R3 zero count start", 16'({tc_o, act_o}), 16'b10);
    // R10 stop while running
    wr(3'd0, 16'h0000);
    arm(16'h0050, 16'h0060, 16'd5);
    wr(3'd0, 16'h0003);
    pulse();
    wr(3'd0, 16'h0002);
    chk("R10 stop clears active", 16'(act_o), 16'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 45) pulse();
      else if (r < 55) wr(3'd1, 16'($urandom));
      else if (r < 65) wr(3'd2, 16'($urandom));
      else if (r < 77) cyc(1'b1, 3'd3, 16'($urandom_range(0, 4)), 1'($urandom_range(0, 1)));
      else if (r < 87) cyc(1'b1, 3'd0, 16'($urandom_range(0, 63)), 1'($urandom_range(0, 1)));
      else if (r < 95) cyc(1'b1, 3'd4, 16'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      else cyc(1'b0, 3'd0, 16'd0, 1'b0);
    end
    finish_run();
  end
endmodule